// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet port and rules on every incoming frame using only its 48-bit destination address. The address arrives with a one-cycle strobe. One clock later the block presents a registered verdict: accept or drop, plus a code that says which rule decided it.

Software configures the filter through a simple write port. The registers are:
- a control word holding the promiscuous, hash-multicast-enable and broadcast-reject bits;
- two 32-bit words that together form a 64-entry multicast hash table;
- a count that splits the exact-match slots between unicast and multicast use;
- eight exact-match address slots, each written as a low word and a high word.

Writing the low word of a slot takes the slot out of service. Writing its high word puts it back. Software can therefore rewrite an entry without a half-updated address ever matching.

The multicast hash index is a 6-bit XOR fold of all 48 address bits. No CRC is involved.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every slot is disarmed, both hash words and all control bits are zero, and the unicast count is zero. `dec_valid` is low, and any frame presented is dropped with reason 0.
- R2: A strobe on `frm_valid` produces exactly one cycle of `dec_valid`, on the cycle after the strobe. `dec_valid` is low in every other cycle.
- R3: When control bit 0 (promiscuous) is set, every frame is accepted with reason 4.
- R4: This rule applies when promiscuous mode is off and the destination is all ones. If control bit 2 (broadcast reject) is set, the frame is dropped with reason 0. Otherwise it is accepted with reason 3.
- R5: Slot i has two registers:
  - its low word is at address 16+2i and carries `frm_dst[31:0]`;
  - its high word is at address 17+2i and carries `frm_dst[47:32]` in bits 15:0.

  Octet n of the address occupies `frm_dst[8n+7:8n]`. An armed slot whose value equals the destination accepts the frame with reason 1.
- R6: Slots with an index below the unicast count (register 3) match only unicast destinations, where `frm_dst[0]` is 0. The remaining slots match only multicast destinations, where `frm_dst[0]` is 1.
- R7: A write of a value from 0 to 8 to the unicast count is stored. A write of a larger value is ignored and leaves the count unchanged.
- R8: A write to a slot's low word disarms that slot. A write to its high word arms it. A disarmed slot never matches.
- R9: The hash index bit j (for j from 0 to 5) is the XOR of every destination bit k with k mod 6 = j. The bits are taken octet 0 first, and least significant bit first within each octet, which is `frm_dst[k]`.
- R10: A hash lookup accepts with reason 2 only when all of the following hold:
  - the destination is multicast;
  - no exact slot matched;
  - control bit 1 (hash enable) is set.

  Index values 0 to 31 select that bit of the low hash word (register 1). Index values 32 to 63 select bit (index−32) of the high hash word (register 2).
- R11: A frame that no rule accepts is dropped with reason 0. `dec_accept` is high exactly when the reason is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register address |
| cfg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Destination address valid strobe |
| frm_dst | input | 48 | Destination address, octet 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 drop, 1 exact, 2 hash, 3 broadcast, 4 promiscuous |

## Verification
Every verdict appears one clock after its strobe. It is computed from the configuration that was in place before that edge. A register write takes effect on the edge at which it is sampled, so the bench finishes each write before it presents the next frame.

The bench drives inputs on the falling edge. It reads the verdict at the next falling edge, which is half a period after the register that produces it has loaded. It then checks one cycle later that `dec_valid` has dropped again. Expected codes are computed from a model of the register state that the bench updates on each write.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
    localparam int MAC_W  = 48;
    localparam int HASH_W = 6;
    localparam int HTBL_W = 2 ** HASH_W;

    typedef enum logic [2:0] {
        RSN_DROP    = 3'd0,
        RSN_EXACT   = 3'd1,
        RSN_HASH    = 3'd2,
        RSN_BCAST   = 3'd3,
        RSN_PROMISC = 3'd4
    } rsn_e;

    typedef struct packed {
        logic bcast_dis;
        logic hash_en;
        logic promisc;
    } ctl_t;

    localparam int REG_CTL   = 0;
    localparam int REG_HLO   = 1;
    localparam int REG_HHI   = 2;
    localparam int REG_UCNT  = 3;
    localparam int SLOT_BASE = 16;
endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int REG_AW    = 5,
    localparam int UW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [REG_AW-1:0]                   wr_addr,
    input  logic [31:0]                         wr_data,
    output ctl_t                                ctl,
    output logic [HTBL_W-1:0]                   hash_tbl,
    output logic [UW-1:0]                       ucnt,
    output logic [NUM_SLOTS-1:0]                armed,
    output logic [NUM_SLOTS-1:0][MAC_W-1:0]     slot
);
    typedef struct packed {
        ctl_t                            ctl;
        logic [HTBL_W-1:0]               hash;
        logic [UW-1:0]                   ucnt;
        logic [NUM_SLOTS-1:0]            armed;
        logic [NUM_SLOTS-1:0][MAC_W-1:0] slot;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == REG_AW'(REG_CTL))  st_d.ctl = ctl_t'(wr_data[2:0]);
            if (wr_addr == REG_AW'(REG_HLO))  st_d.hash[31:0]  = wr_data;
            if (wr_addr == REG_AW'(REG_HHI))  st_d.hash[63:32] = wr_data;
            if (wr_addr == REG_AW'(REG_UCNT) && wr_data <= 32'(NUM_SLOTS))
                st_d.ucnt = wr_data[UW-1:0];
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_addr == REG_AW'(SLOT_BASE + 2 * i)) begin
                    st_d.slot[i][31:0] = wr_data;
                    st_d.armed[i]      = 1'b0;
                end
                if (wr_addr == REG_AW'(SLOT_BASE + 2 * i + 1)) begin
                    st_d.slot[i][MAC_W-1:32] = wr_data[MAC_W-33:0];
                    st_d.armed[i]            = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl      = st_q.ctl;
    assign hash_tbl = st_q.hash;
    assign ucnt     = st_q.ucnt;
    assign armed    = st_q.armed;
    assign slot     = st_q.slot;
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
(
    input  logic [MAC_W-1:0]  dst,
    output logic [HASH_W-1:0] idx
);
    localparam int GROUPS = MAC_W / HASH_W;

    for (genvar j = 0; j < HASH_W; j++) begin : g_fold
        logic [GROUPS-1:0] pick;
        for (genvar m = 0; m < GROUPS; m++) begin : g_pick
            assign pick[m] = dst[HASH_W * m + j];
        end
        assign idx[j] = ^pick;
    end
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int UW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic [MAC_W-1:0]                dst,
    input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot,
    input  logic [NUM_SLOTS-1:0]            armed,
    input  logic [UW-1:0]                   ucnt,
    output logic                            hit
);
    logic [NUM_SLOTS-1:0] slot_hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic uc_slot;
        logic class_ok;
        assign uc_slot     = UW'(i) < ucnt;
        assign class_ok    = uc_slot ? ~dst[0] : dst[0];
        assign slot_hit[i] = armed[i] & class_ok & (slot[i] == dst);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int REG_AW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              frm_valid,
    input  logic [47:0]       frm_dst,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_reason
);
    localparam int UW = $clog2(NUM_SLOTS + 1);

    typedef struct packed {
        logic valid;
        logic accept;
        rsn_e rsn;
    } out_t;

    ctl_t                            ctl_w;
    logic [HTBL_W-1:0]               hash_w;
    logic [UW-1:0]                   ucnt_w;
    logic [NUM_SLOTS-1:0]            armed_w;
    logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_w;
    logic [HASH_W-1:0]               hidx_w;
    logic                            exact_hit_w;
    out_t                            out_d, out_q;

    rxaf_regs #(.NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .ctl      (ctl_w),
        .hash_tbl (hash_w),
        .ucnt     (ucnt_w),
        .armed    (armed_w),
        .slot     (slot_w)
    );

    rxaf_hash i_hash (
        .dst (frm_dst),
        .idx (hidx_w)
    );

    rxaf_match #(.NUM_SLOTS(NUM_SLOTS)) i_match (
        .dst   (frm_dst),
        .slot  (slot_w),
        .armed (armed_w),
        .ucnt  (ucnt_w),
        .hit   (exact_hit_w)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = frm_valid;
        if (frm_valid) begin
            if (ctl_w.promisc)
                out_d.rsn = RSN_PROMISC;
            else if (&frm_dst)
                out_d.rsn = ctl_w.bcast_dis ? RSN_DROP : RSN_BCAST;
            else if (exact_hit_w)
                out_d.rsn = RSN_EXACT;
            else if (frm_dst[0] && ctl_w.hash_en && hash_w[hidx_w])
                out_d.rsn = RSN_HASH;
            else
                out_d.rsn = RSN_DROP;
            out_d.accept = (out_d.rsn != RSN_DROP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dec_valid  = out_q.valid;
    assign dec_accept = out_q.accept;
    assign dec_reason = out_q.rsn;
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
    parameter int NUM_SLOTS = 8,
    localparam int UW       = $clog2(NUM_SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_valid,
    input logic [47:0]   frm_dst,
    input logic          dec_valid,
    input logic          dec_accept,
    input logic [2:0]    dec_reason,
    input logic [2:0]    ctl_bits,
    input logic [UW-1:0] ucnt
);
    p_verdict_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid);
    p_promisc_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && ctl_bits[0] |=> dec_reason == 3'd4);
    p_bcast_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !ctl_bits[0] && (&frm_dst) |=>
            dec_reason == (ctl_bits[2] ? 3'd0 : 3'd3));
    p_ucnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt <= UW'(NUM_SLOTS));
    p_hash_needs_mcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (!frm_dst[0] || !ctl_bits[1]) |=> dec_reason != 3'd2);
    p_accept_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_accept == (dec_reason != 3'd0));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept && dec_reason == 3'd0);
endmodule

bind rx_addr_filter rxaf_checker #(.NUM_SLOTS(NUM_SLOTS)) i_rxaf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_dst    (frm_dst),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_reason (dec_reason),
    .ctl_bits   (ctl_w),
    .ucnt       (ucnt_w)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_reason;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model of the programmed state
    logic [2:0]  m_ctl;
    logic [63:0] m_hash;
    int          m_ucnt;
    logic [47:0] m_slot [8];
    bit          m_armed [8];

    always #5 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_dst(frm_dst),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    function automatic int ref_hash(logic [47:0] a);
        int h = 0;
        int pos = 0;
        for (int oct = 0; oct < 6; oct++) begin
            logic [7:0] c = a[8*oct +: 8];
            for (int b = 0; b < 8; b++) begin
                h = h ^ (int'(c[0]) << pos);
                c = c >> 1;
                pos = (pos == 5) ? 0 : pos + 1;
            end
        end
        return h;
    endfunction

    function automatic int ref_reason(logic [47:0] a);
        int h;
        if (m_ctl[0]) return 4;
        if (a == 48'hFFFF_FFFF_FFFF) return m_ctl[2] ? 0 : 3;
        for (int i = 0; i < 8; i++)
            if (m_armed[i] && m_slot[i] == a && ((i < m_ucnt) == (a[0] == 1'b0)))
                return 1;
        h = ref_hash(a);
        if (a[0] && m_ctl[1]) begin
            if (h < 32) begin
                if (m_hash[h]) return 2;
            end else if (m_hash[32 + (h - 32)]) return 2;
        end
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (addr)
            0: m_ctl = data[2:0];
            1: m_hash[31:0] = data;
            2: m_hash[63:32] = data;
            3: if (data <= 8) m_ucnt = int'(data);
            default: if (addr >= 16 && addr < 32) begin
                if (addr % 2 == 0) begin
                    m_slot[(addr-16)/2][31:0] = data; m_armed[(addr-16)/2] = 0;
                end else begin
                    m_slot[(addr-16)/2][47:32] = data[15:0]; m_armed[(addr-16)/2] = 1;
                end
            end
        endcase
    endtask

    task automatic put_slot(int i, logic [47:0] a);
        wr(16 + 2*i, a[31:0]);
        wr(17 + 2*i, {16'h0, a[47:32]});
    endtask

    task automatic frame(string req, logic [47:0] a);
        int exp;
        @(negedge clk);
        frm_valid = 1'b1; frm_dst = a;
        exp = ref_reason(a);
        @(negedge clk);
        frm_valid = 1'b0;
        check({req, " valid"}, int'(dec_valid), 1);
        check({req, " reason"}, int'(dec_reason), exp);
        check({req, " accept"}, int'(dec_accept), int'(exp != 0));
    endtask

    task automatic frame_exp(string req, logic [47:0] a, int exp);
        check({req, " model"}, ref_reason(a), exp);
        frame(req, a);
    endtask

    function automatic logic [47:0] rnd_addr(bit mcast);
        logic [47:0] a = {$urandom, $urandom};
        a[0] = mcast;
        return a;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta, mc, mc_lo, mc_hi, other;
        void'($urandom(32'd4242));
        m_ctl = '0; m_hash = '0; m_ucnt = 0;
        for (int i = 0; i < 8; i++) begin m_slot[i] = '0; m_armed[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 dec_valid after reset", int'(dec_valid), 0);
        frame_exp("R1 unicast zero addr dropped", 48'h0, 0);
        frame_exp("R1 mcast dropped", rnd_addr(1), 0);

        // R2: strobe yields single verdict cycle
        @(negedge clk);
        check("R2 idle no verdict", int'(dec_valid), 0);

        // R5: station address in slot 0
        sta = 48'h5544_3322_1100;
        wr(3, 1);
        put_slot(0, sta);
        frame_exp("R5 station exact", sta, 1);
        @(negedge clk);
        check("R2 verdict lasts one cycle", int'(dec_valid), 0);
        frame_exp("R11 near miss dropped", sta ^ 48'h0100_0000_0000, 0);

        // R8: low write disarms, high write arms
        other = 48'h0000_AABB_CC10;
        wr(16, other[31:0]);
        frame_exp("R8 disarmed old addr", sta, 0);
        frame_exp("R8 disarmed new addr", other, 0);
        wr(17, {16'h0, other[47:32]});
        frame_exp("R8 rearmed new addr", other, 1);

        // R6/R7: unicast count partitions slots
        other = 48'h1234_5678_9A02;
        put_slot(3, other);
        frame_exp("R6 unicast in mcast slot", other, 0);
        wr(3, 9);
        frame_exp("R7 count 9 ignored", other, 0);
        wr(3, 8);
        frame_exp("R7 count 8 stored", other, 1);
        mc = 48'h0000_5E00_0101;
        put_slot(5, mc);
        frame_exp("R6 mcast in unicast slot", mc, 0);
        wr(3, 2);
        frame_exp("R6 mcast slot match", mc, 1);

        // R4: broadcast
        frame_exp("R4 broadcast accepted", 48'hFFFF_FFFF_FFFF, 3);
        wr(0, 32'h4);
        frame_exp("R4 broadcast rejected", 48'hFFFF_FFFF_FFFF, 0);

        // R9/R10: hash, low and high words
        check("R9 fold of bit 6", ref_hash(48'h40), 1);
        check("R9 fold of bit 47", ref_hash(48'h8000_0000_0000), 32'd5 == 5 ? 32 : 0);
        do mc_lo = rnd_addr(1); while (ref_hash(mc_lo) >= 32);
        do mc_hi = rnd_addr(1); while (ref_hash(mc_hi) < 32);
        wr(1, 32'(1) << ref_hash(mc_lo));
        wr(2, 32'(1) << (ref_hash(mc_hi) - 32));
        frame_exp("R10 hash disabled", mc_lo, 0);
        wr(0, 32'h2);
        frame_exp("R10 hash low word", mc_lo, 2);
        frame_exp("R10 hash high word", mc_hi, 2);
        wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
        frame("R10 unicast never hashes", rnd_addr(0));
        frame_exp("R10 exact before hash", mc, 1);
        wr(1, 0); wr(2, 0);
        frame_exp("R10 empty table", mc_lo, 0);

        // R3: promiscuous
        wr(0, 32'h7);
        frame_exp("R3 promisc unicast", rnd_addr(0), 4);
        frame_exp("R3 promisc broadcast", 48'hFFFF_FFFF_FFFF, 4);
        wr(0, 32'h2);

        // random mix (R5 R6 R8 R9 R10 R11)
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 9);
            logic [47:0] a;
            if (sel < 2) begin
                int s = $urandom_range(0, 7);
                if ($urandom_range(0, 3) == 0) wr(16 + 2*s, $urandom);
                else put_slot(s, rnd_addr(1'($urandom)));
            end else if (sel == 2) begin
                wr($urandom_range(0, 3), $urandom_range(0, 3) == 3 ? 32'($urandom_range(0, 12)) : $urandom);
                if (m_ctl[0] && $urandom_range(0, 1) == 1) wr(0, {29'h0, m_ctl[2:1], 1'b0});
            end else begin
                int pick = $urandom_range(0, 9);
                if (pick < 5) a = m_slot[$urandom_range(0, 7)];
                else if (pick == 5) a = 48'hFFFF_FFFF_FFFF;
                else a = rnd_addr(1'($urandom));
                frame("R11 random", a);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule